// File: doc/BRIEF.md
# Twisted-Pair Receive Squelch Qualifier

This block decides whether a 10 Mb/s twisted-pair receive input carries real data or only impulse noise. It takes four digitized comparator flags: the positive and the negative input, each checked against a normal threshold and against a reduced threshold. The flags arrive asynchronously, so each one passes through a synchronizer. A crossing is the rising edge of a synchronized flag.

To qualify a packet, the block needs three crossings of alternating polarity. The first crossing may be of either polarity. Each later crossing must arrive within a window of `WIN` clock cycles after the previous one. Once the third crossing is seen, the block raises its data-valid output. It also tells the comparators to switch to the reduced thresholds, which gives hysteresis against a premature end of packet.

While data is valid, every reduced-threshold crossing of either polarity restarts the window. A full window with no such crossing ends the packet. Data-valid then falls, a one-cycle end-of-packet pulse is given, the normal thresholds return, and the block waits for a new first crossing. The behaviour is the same in half-duplex and full-duplex operation.

Top module: `sq_qualifier`

## Requirements
- R1: While `rst_n` is low, `data_valid`, `eop` and `thr_reduced` are all 0.
- R2: When not valid, only the normal-threshold flags (`cmp_pos_hi`, `cmp_neg_hi`) count as crossings. Either polarity can start a qualification. Rising edges of the reduced-threshold flags are ignored.
- R3: The opposite-polarity crossing must rise 1 to `WIN` cycles after the first crossing rose. If it does not, the sequence is abandoned without asserting `data_valid`.
- R4: A repeat of the same polarity while the block waits for the opposite one neither advances the sequence nor restarts the window.
- R5: A crossing of the original polarity, 1 to `WIN` cycles after the second crossing, sets `data_valid`. It goes high at the third rising clock edge after the cycle in which that flag is first presented.
- R6: `thr_reduced` is 1 exactly while `data_valid` is 1. While valid, the normal-threshold flags are ignored.
- R7: While valid, each rising edge of `cmp_pos_lo` or `cmp_neg_lo` restarts the window. After `WIN` cycles with no such edge, `data_valid` falls, and `eop` is 1 for exactly that first invalid cycle.
- R8: If both normal flags rise in the same cycle while the block is idle, the positive polarity is taken as the first crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_pos_hi | input | 1 | Positive input above the normal threshold |
| cmp_neg_hi | input | 1 | Negative input above the normal threshold |
| cmp_pos_lo | input | 1 | Positive input above the reduced threshold |
| cmp_neg_lo | input | 1 | Negative input above the reduced threshold |
| thr_reduced | output | 1 | 1 selects the reduced comparator thresholds |
| data_valid | output | 1 | Qualified receive data present |
| eop | output | 1 | One-cycle end-of-packet pulse |

## Verification
Every result comes out three rising edges after a flag is presented: two synchronizer stages, then the state register. The `eop` pulse appears in the same cycle that `data_valid` falls. The bench drives inputs and samples outputs on the falling clock edge. It feeds its reference model the inputs delayed by exactly three cycles, so each comparison lands in the cycle the requirement names. The directed cases wait that same three-cycle latency before they check, and they place crossings exactly at `WIN` and at `WIN`+1 cycles apart.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_W2    = 2'd1,
    ST_W3    = 2'd2,
    ST_VALID = 2'd3
  } sq_state_e;

  // flag bit positions inside the synchronized vector
  localparam int F_PH = 0;
  localparam int F_NH = 1;
  localparam int F_PL = 2;
  localparam int F_NL = 3;
  localparam int NFLAG = 4;
endpackage

// File: rtl/sq_sync.sv
module sq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] rise
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[STAGES-1];
  end

  assign rise = stg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sq_timer.sv
module sq_timer #(
  parameter int WIN = 15,
  localparam int CW = (WIN > 2) ? $clog2(WIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          expire,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_nxt;
  logic          cnt_en;

  assign cnt_en = run & ~restart & ~expire;

  always_comb begin
    cnt_nxt = cnt;
    if (!run || restart || expire) cnt_nxt = '0;
    else if (cnt_en)               cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/sq_fsm.sv
module sq_fsm
  import sq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] rise,
  input  logic             expire,
  output sq_state_e        st,
  output logic             restart,
  output logic             dv,
  output logic             thr,
  output logic             eop
);
  sq_state_e nxt;
  logic      pol_q, pol_nxt;   // 0: started positive, 1: started negative
  logic      eop_nxt;
  logic      opp_x, orig_x, low_x;

  assign opp_x  = pol_q ? rise[F_PH] : rise[F_NH];
  assign orig_x = pol_q ? rise[F_NH] : rise[F_PH];
  assign low_x  = rise[F_PL] | rise[F_NL];

  always_comb begin
    nxt     = st;
    pol_nxt = pol_q;
    restart = 1'b0;
    eop_nxt = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (rise[F_PH])      begin nxt = ST_W2; pol_nxt = 1'b0; end
        else if (rise[F_NH]) begin nxt = ST_W2; pol_nxt = 1'b1; end
      end
      ST_W2: begin
        if (opp_x)       begin nxt = ST_W3; restart = 1'b1; end
        else if (expire) nxt = ST_IDLE;
      end
      ST_W3: begin
        if (orig_x)      begin nxt = ST_VALID; restart = 1'b1; end
        else if (expire) nxt = ST_IDLE;
      end
      ST_VALID: begin
        if (low_x)       restart = 1'b1;
        else if (expire) begin nxt = ST_IDLE; eop_nxt = 1'b1; end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      pol_q <= 1'b0;
      dv    <= 1'b0;
      thr   <= 1'b0;
      eop   <= 1'b0;
    end else begin
      st    <= nxt;
      pol_q <= pol_nxt;
      dv    <= (nxt == ST_VALID);
      thr   <= (nxt == ST_VALID);
      eop   <= eop_nxt;
    end
  end
endmodule

// File: rtl/sq_qualifier.sv
module sq_qualifier
  import sq_pkg::*;
#(
  parameter int WIN         = 15,
  parameter int SYNC_STAGES = 2,
  localparam int CW = (WIN > 2) ? $clog2(WIN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_pos_hi,
  input  logic cmp_neg_hi,
  input  logic cmp_pos_lo,
  input  logic cmp_neg_lo,
  output logic thr_reduced,
  output logic data_valid,
  output logic eop
);
  logic [NFLAG-1:0] raw, rise;
  sq_state_e        st;
  logic [CW-1:0]    cnt;
  logic             run, restart, expire;

  always_comb begin
    raw       = '0;
    raw[F_PH] = cmp_pos_hi;
    raw[F_NH] = cmp_neg_hi;
    raw[F_PL] = cmp_pos_lo;
    raw[F_NL] = cmp_neg_lo;
  end

  sq_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw), .rise(rise)
  );

  assign run    = (st != ST_IDLE);
  assign expire = run && (cnt == CW'(WIN - 1));

  sq_timer #(.WIN(WIN)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .expire(expire), .cnt(cnt)
  );

  sq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(rise), .expire(expire),
    .st(st), .restart(restart), .dv(data_valid), .thr(thr_reduced), .eop(eop)
  );
endmodule

// File: rtl/sq_qualifier_chk.sv
module sq_qualifier_chk
  import sq_pkg::*;
#(
  parameter int WIN = 15,
  localparam int CW = (WIN > 2) ? $clog2(WIN) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          data_valid,
  input logic          thr_reduced,
  input logic          eop,
  input sq_state_e     st,
  input logic [CW-1:0] cnt
);
  assert_eop_at_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> (!data_valid && $past(data_valid)));

  assert_eop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> !eop);

  assert_valid_from_w3_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(st == ST_W3));

  assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(WIN));

  assert_thr_off_unless_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_VALID) |-> !thr_reduced);
endmodule

bind sq_qualifier sq_qualifier_chk #(.WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_valid(data_valid), .thr_reduced(thr_reduced),
  .eop(eop), .st(st), .cnt(cnt)
);

// File: tb/sq_qualifier_tb.sv
module sq_qualifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 15;
  localparam logic [3:0] PH = 4'b0001, NH = 4'b0010, PL = 4'b0100, NL = 4'b1000;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] drv;
  logic thr_reduced, data_valid, eop;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sq_qualifier #(.WIN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmp_pos_hi(drv[0]), .cmp_neg_hi(drv[1]), .cmp_pos_lo(drv[2]), .cmp_neg_lo(drv[3]),
    .thr_reduced(thr_reduced), .data_valid(data_valid), .eop(eop)
  );

  // reference model state, fed with inputs delayed three cycles
  logic [3:0] d1, d2, d3, d4;
  int m_st, m_cnt;
  bit m_pol, m_eop;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic [3:0] cur, input logic [3:0] old);
    logic [3:0] e;
    bit ex;
    e = cur & ~old;
    ex = (m_st != 0) && (m_cnt == WIN - 1);
    m_eop = 0;
    case (m_st)
      0: begin
        m_cnt = 0;
        if (e[0])      begin m_st = 1; m_pol = 0; end
        else if (e[1]) begin m_st = 1; m_pol = 1; end
      end
      1: if (m_pol ? e[0] : e[1]) begin m_st = 2; m_cnt = 0; end
         else if (ex) begin m_st = 0; m_cnt = 0; end
         else m_cnt++;
      2: if (m_pol ? e[1] : e[0]) begin m_st = 3; m_cnt = 0; end
         else if (ex) begin m_st = 0; m_cnt = 0; end
         else m_cnt++;
      default: if (e[2] | e[3]) m_cnt = 0;
         else if (ex) begin m_st = 0; m_cnt = 0; m_eop = 1; end
         else m_cnt++;
    endcase
  endtask

  task automatic cyc(input logic [3:0] v);
    @(negedge clk);
    model_step(d3, d4);
    chk("R5 data_valid", data_valid, m_st == 3);
    chk("R7 eop", eop, m_eop);
    chk("R6 thr_reduced", thr_reduced, m_st == 3);
    d4 = d3; d3 = d2; d2 = d1; d1 = v;
    drv = v;
  endtask

  task automatic pulse(input logic [3:0] v, input int gap);
    cyc(v);
    repeat (gap - 1) cyc(4'b0);
  endtask

  task automatic quiet(input int n);
    repeat (n) cyc(4'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; drv = '0;
    d1 = '0; d2 = '0; d3 = '0; d4 = '0;
    m_st = 0; m_cnt = 0; m_pol = 0; m_eop = 0;
    repeat (3) @(negedge clk);
    chk("R1 data_valid in reset", data_valid, 1'b0);
    chk("R1 eop in reset", eop, 1'b0);
    chk("R1 thr_reduced in reset", thr_reduced, 1'b0);
    rst_n = 1'b1;

    // positive-first, crossings exactly WIN apart
    pulse(PH, WIN); pulse(NH, WIN); cyc(PH); quiet(3);
    chk("R5 valid after three crossings", data_valid, 1'b1);
    chk("R6 reduced thresholds while valid", thr_reduced, 1'b1);
    repeat (4) pulse(PL, WIN);
    chk("R7 reduced crossings keep valid", data_valid, 1'b1);
    cyc(PL); quiet(2);
    repeat (5) pulse(PH, 4);
    chk("R6 normal flags ignored while valid", data_valid, 1'b0);
    quiet(20);

    // negative-first, back to back
    cyc(NH); cyc(PH); cyc(NH); quiet(3);
    chk("R2 negative first crossing qualifies", data_valid, 1'b1);
    quiet(30);

    // second crossing one cycle too late
    pulse(PH, WIN + 1); pulse(NH, 3); cyc(PH); quiet(3);
    chk("R3 late opposite crossing rejected", data_valid, 1'b0);
    quiet(30);

    // repeated same polarity must not restart the window
    pulse(PH, 5); pulse(PH, WIN - 4); pulse(NH, 3); cyc(PH); quiet(3);
    chk("R4 same-polarity repeat does not restart window", data_valid, 1'b0);
    quiet(30);

    // simultaneous first crossings: positive wins
    cyc(PH | NH); cyc(4'b0); cyc(NH); cyc(PH); quiet(3);
    chk("R8 positive taken on simultaneous start", data_valid, 1'b1);
    quiet(30);

    // reduced flags ignored while idle
    cyc(PL); cyc(NL); cyc(PL); quiet(3);
    chk("R2 reduced flags ignored when idle", data_valid, 1'b0);
    quiet(5);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] v;
      for (int b = 0; b < 4; b++) v[b] = (($urandom % 6) == 0);
      cyc(v);
    end
    quiet(40);

    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule